// File: doc/BRIEF.md
# Transmit Frame Pad Stripper

This block sits on a 64-bit AXI4-Stream transmit path. Each frame that arrives on its input carries six filler bytes ahead of the real Ethernet header. The block removes those bytes and shifts the remaining byte lanes across word boundaries, so that the destination address of each outgoing frame starts in the first byte of the first output word. It works out a new byte count for the final word of each frame and flags the first word of each frame on a sideband bit.

Bytes travel most-significant first: byte 0 of a word is `tdata[63:56]`. On the final beat, sideband bits 2:0 give the number of valid bytes, and the value 0 means all eight are valid. Sideband bit 3 is an error flag on the input and is not used. On the output, the same bit marks the start of a frame. Each output word is made of the two trailing bytes of input word N followed by the six leading bytes of input word N+1. Both sides follow full valid/ready flow control. A synchronous clear input abandons any partly forwarded frame.

Top module: `pad_strip`

## Requirements
- R1: The output byte stream of a frame is the input byte stream with its first six bytes removed, and output byte 0 is placed in `m_tdata[63:56]`.
- R2: The first input beat of a frame is accepted at once (`s_tready` high) and produces no output beat in that cycle.
- R3: When the last input word holds 1 to 6 valid bytes, its bytes are merged into the output word that the previous input word began. That word is the tlast beat, with `m_tuser[2:0]` equal to (input count + 2) modulo 8. Non-final output beats carry `m_tuser[2:0]` = 0.
- R4: When the last input word holds 7 or 8 valid bytes (code 7 or 0), one extra final output beat follows, with 1 or 2 valid bytes respectively.
- R5: `m_tuser[3]` is 1 on the first output beat of each frame and 0 on every other beat. `s_tuser[3]` has no effect on the output.
- R6: While `m_tvalid` is high and `m_tready` is low, the output beat holds steady. No beat is lost or duplicated, whatever pattern of input gaps and output stalls occurs.
- R7: A high `clear` drops any partial frame. `m_tvalid` is low in the following cycle, and the next frame is stripped correctly and flagged as a start of frame.
- R8: After reset, `m_tvalid` is low and `s_tready` is high.
- R9: A frame of 7 or 8 bytes produces a single tlast beat holding 1 or 2 bytes. A frame of 6 bytes or fewer produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear; returns the block to start-of-frame |
| s_tdata | input | 64 | Input data, byte 0 in the top lane |
| s_tuser | input | 4 | [2:0] last-beat byte count (0 = 8); [3] ignored |
| s_tlast | input | 1 | Last input beat of a frame |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block accepts the input beat |
| m_tdata | output | 64 | Output data with the pad removed |
| m_tuser | output | 4 | [2:0] last-beat byte count (0 = 8); [3] start of frame |
| m_tlast | output | 1 | Last output beat of a frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the output beat |

## Verification
The bench builds the block with its default pad width of six bytes. This makes the lane shift a fixed two-plus-six split, so every final-word byte count from 1 to 8 falls either on the merged-beat path or on the extra-beat path. Sweeping frame lengths from 1 to 30 bytes, plus longer frames, covers both paths, the single-word frames and the frames that vanish entirely. The same lengths are then run again with input gaps and output stalls at unrelated periods, so that a stall lands in turn on the first, middle, merged and extra beats.

// File: rtl/pad_strip.sv
module pad_strip #(
  parameter int PAD_BYTES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic [63:0] s_tdata,
  input  logic [3:0]  s_tuser,
  input  logic        s_tlast,
  input  logic        s_tvalid,
  output logic        s_tready,
  output logic [63:0] m_tdata,
  output logic [3:0]  m_tuser,
  output logic        m_tlast,
  output logic        m_tvalid,
  input  logic        m_tready
);

  localparam int KEEP   = 8 - PAD_BYTES;
  localparam int HOLD_W = KEEP * 8;

  typedef enum logic [1:0] {ST_HEAD, ST_BODY, ST_TAIL} st_t;

  st_t               st;
  logic [HOLD_W-1:0] hold;
  logic              sof_q;
  logic [2:0]        tail_code;

  logic [3:0] in_cnt;
  logic [3:0] merged_sum;
  logic [3:0] tail_sum;
  logic       fits;
  logic       unused_err;

  assign unused_err = s_tuser[3];
  assign in_cnt     = (s_tuser[2:0] == 3'd0) ? 4'd8 : {1'b0, s_tuser[2:0]};
  assign fits       = in_cnt <= 4'(PAD_BYTES);
  assign merged_sum = in_cnt + 4'(KEEP);
  assign tail_sum   = in_cnt - 4'(PAD_BYTES);

  always_comb begin
    s_tready = 1'b0;
    m_tvalid = 1'b0;
    m_tlast  = 1'b0;
    m_tdata  = {hold, s_tdata[63:HOLD_W]};
    m_tuser  = {sof_q, 3'd0};
    case (st)
      ST_HEAD: s_tready = 1'b1;
      ST_BODY: begin
        s_tready = m_tready;
        m_tvalid = s_tvalid;
        m_tlast  = s_tlast && fits;
        if (s_tlast && fits) m_tuser[2:0] = merged_sum[2:0];
      end
      ST_TAIL: begin
        m_tvalid = 1'b1;
        m_tlast  = 1'b1;
        m_tdata  = {hold, {(64-HOLD_W){1'b0}}};
        m_tuser  = {sof_q, tail_code};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st        <= ST_HEAD;
      hold      <= '0;
      sof_q     <= 1'b0;
      tail_code <= 3'd0;
    end else begin
      case (st)
        ST_HEAD: if (s_tvalid) begin
          hold  <= s_tdata[HOLD_W-1:0];
          sof_q <= 1'b1;
          if (!s_tlast) st <= ST_BODY;
          else if (!fits) begin
            st        <= ST_TAIL;
            tail_code <= tail_sum[2:0];
          end
        end
        ST_BODY: if (s_tvalid && m_tready) begin
          hold  <= s_tdata[HOLD_W-1:0];
          sof_q <= 1'b0;
          if (s_tlast) begin
            if (fits) st <= ST_HEAD;
            else begin
              st        <= ST_TAIL;
              tail_code <= tail_sum[2:0];
            end
          end
        end
        ST_TAIL: if (m_tready) begin
          st    <= ST_HEAD;
          sof_q <= 1'b0;
        end
        default: st <= ST_HEAD;
      endcase
    end
  end

endmodule

// File: rtl/pad_strip_chk.sv
module pad_strip_chk (
  input logic        clk,
  input logic        rst,
  input logic        clear,
  input logic        s_tlast,
  input logic        s_tvalid,
  input logic        s_tready,
  input logic [63:0] m_tdata,
  input logic [3:0]  m_tuser,
  input logic        m_tlast,
  input logic        m_tvalid,
  input logic        m_tready
);

  logic in_first;
  logic out_first;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      in_first  <= 1'b1;
      out_first <= 1'b1;
    end else begin
      if (s_tvalid && s_tready) in_first  <= s_tlast;
      if (m_tvalid && m_tready) out_first <= m_tlast;
    end
  end

  a_r2_first_silent: assert property (@(posedge clk) disable iff (rst)
    (in_first && s_tvalid && s_tready) |-> !m_tvalid);

  a_r3_nonlast_code: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tlast) |-> (m_tuser[2:0] == 3'd0));

  a_r5_sof_mark: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> (m_tuser[3] == out_first));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready && !clear) |=>
      (clear || (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast))));

  a_r7_clear_idle: assert property (@(posedge clk) disable iff (rst)
    clear |=> !m_tvalid);

  a_r8_reset_idle: assert property (@(posedge clk)
    rst |=> (!m_tvalid && s_tready));

endmodule

bind pad_strip pad_strip_chk chk_i (
  .clk(clk), .rst(rst), .clear(clear),
  .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
  .m_tvalid(m_tvalid), .m_tready(m_tready)
);

// File: tb/pad_strip_tb_top.sv
module pad_strip_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic [63:0] s_tdata = '0;
  logic [3:0]  s_tuser = '0;
  logic        s_tlast = 1'b0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic [3:0]  m_tuser;
  logic        m_tlast;
  logic        m_tvalid;
  logic        m_tready = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] frm [0:255];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pad_strip dut_i (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_frame(input int len, input bit err, input bit mode);
    int beats = (len + 7) / 8;
    for (int b = 0; b < beats; b++) begin
      int occ = (b == beats - 1) ? len - 8 * b : 8;
      bit hs;
      if (mode) while (cyc % 4 == 2) begin s_tvalid = 1'b0; @(negedge clk); end
      for (int k = 0; k < 8; k++) s_tdata[63-8*k -: 8] = (k < occ) ? frm[8*b+k] : 8'hEE;
      s_tuser  = {err, 3'(occ % 8)};
      s_tlast  = (b == beats - 1);
      s_tvalid = 1'b1;
      do begin #1; hs = s_tready; @(negedge clk); end while (!hs);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic collect_frame(input int len, input bit mode, input int wait_cyc);
    int total = len - 6;
    int idx = 0;
    bit first = 1'b1;
    bit done = 1'b0;
    bit stalled = 1'b0;
    logic [63:0] prev = '0;
    if (total <= 0) begin
      bit seen = 1'b0;
      for (int c = 0; c < wait_cyc; c++) begin #1; if (m_tvalid) seen = 1'b1; @(negedge clk); end
      check(!seen, "R9", "short frame produced output", 64'(seen), 64'd0);
      return;
    end
    while (!done) begin
      m_tready = mode ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (stalled && m_tvalid)
        check(m_tdata == prev, "R6", "stalled beat changed", m_tdata, prev);
      stalled = m_tvalid && !m_tready;
      prev = m_tdata;
      if (m_tvalid && m_tready) begin
        int occ = m_tlast ? ((m_tuser[2:0] == 3'd0) ? 8 : int'(m_tuser[2:0])) : 8;
        bit ok = 1'b1;
        logic [63:0] expw = '0;
        for (int j = 0; j < 8; j++) begin
          expw[63-8*j -: 8] = (idx + j < total) ? frm[6+idx+j] : 8'h00;
          if (j < occ && (idx + j >= total || m_tdata[63-8*j -: 8] != frm[6+idx+j])) ok = 1'b0;
        end
        check(ok, "R1", $sformatf("len %0d data at byte %0d", len, idx), m_tdata, expw);
        check(m_tuser[3] == first, "R5", "start-of-frame flag", 64'(m_tuser[3]), 64'(first));
        check(m_tlast == (idx + occ >= total), "R3", $sformatf("len %0d tlast position", len),
              64'(m_tlast), 64'(idx + occ >= total));
        if (!m_tlast)
          check(m_tuser[2:0] == 3'd0, "R3", "non-final count code", 64'(m_tuser[2:0]), 64'd0);
        else
          check(occ == total - idx, (((len - 1) % 8) + 1 > 6) ? "R4" : "R3",
                $sformatf("len %0d final count", len), 64'(occ), 64'(total - idx));
        first = 1'b0;
        idx += occ;
        done = m_tlast;
      end
      @(negedge clk);
    end
    m_tready = 1'b1;
  endtask

  task automatic run_frame(input int len, input bit err, input bit mode, input int seed);
    for (int i = 0; i < 256; i++) frm[i] = 8'((seed * 37 + i * 5 + 1) & 255);
    fork
      drive_frame(len, err, mode);
      collect_frame(len, mode, 8);
    join
  endtask

  task automatic t_reset();
    #1;
    check(!m_tvalid, "R8", "m_tvalid after reset", 64'(m_tvalid), 64'd0);
    check(s_tready, "R8", "s_tready after reset", 64'(s_tready), 64'd1);
  endtask

  task automatic t_sweep();
    for (int l = 7; l <= 30; l++) run_frame(l, 1'b0, 1'b0, l);
    run_frame(100, 1'b0, 1'b0, 3);
  endtask

  task automatic t_short();
    for (int l = 1; l <= 6; l++) run_frame(l, 1'b0, 1'b0, l);
    run_frame(7, 1'b0, 1'b0, 40);
    run_frame(8, 1'b0, 1'b0, 41);
  endtask

  task automatic t_stall();
    for (int l = 7; l <= 26; l++) run_frame(l, 1'b0, 1'b1, l + 50);
    run_frame(63, 1'b0, 1'b1, 7);
    run_frame(64, 1'b0, 1'b1, 8);
  endtask

  task automatic t_err_ignored();
    run_frame(21, 1'b1, 1'b0, 90);
    run_frame(24, 1'b1, 1'b1, 91);
    run_frame(8, 1'b1, 1'b0, 92);
  endtask

  task automatic t_clear();
    bit hs;
    m_tready = 1'b0;
    s_tdata  = 64'h0102030405060708;
    s_tuser  = 4'd0;
    s_tlast  = 1'b0;
    s_tvalid = 1'b1;
    do begin #1; hs = s_tready; @(negedge clk); end while (!hs);
    s_tdata = 64'h1112131415161718;
    #1;
    check(m_tvalid && !s_tready, "R6", "stalled middle beat", {m_tvalid, s_tready}, 64'd2);
    @(negedge clk);
    s_tvalid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    #1;
    check(!m_tvalid, "R7", "m_tvalid after clear", 64'(m_tvalid), 64'd0);
    @(negedge clk);
    m_tready = 1'b1;
    run_frame(19, 1'b0, 1'b0, 77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_sweep();
    t_short();
    t_stall();
    t_err_ignored();
    t_clear();
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule